// File: doc/BRIEF.md
# Direction-Configurable General-Purpose Pin Controller

This block drives seven general-purpose pins from two small configuration registers that software reaches over a plain address/data strobe bus. The first register picks, pin by pin, whether the pin listens or drives. The second register holds one bit per pin whose meaning changes with that choice. On a listening pin it selects whether the external signal is asserted high or asserted low. On a driving pin it selects between a push-pull (CMOS) driver and an open-drain driver.

For each pin the block produces a pad data value, a pad driver enable and a normalised input value, all registered. The normalised input reports 1 whenever the external signal is asserted, whatever its polarity. Core logic supplies the value to drive on each pin through a per-pin data input. An open-drain pin pulls its pad low for a 0 and releases it for a 1. A listening pin never turns on its driver.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the direction register becomes 0x00, the polarity/type register becomes 0x7F, and `pad_oe`, `pad_out`, `in_value` and `bus_rdata` all become 0 after that edge.
- R2: A write to address 0x2C loads bits 6:0 of `bus_wdata` into the direction register. Bit i controls pin i, with 1 meaning output and 0 meaning input. A read of 0x2C returns the register in bits 6:0.
- R3: A write to address 0x2D loads bits 6:0 into the polarity/type register, with bit i belonging to pin i. A read of 0x2D returns the register in bits 6:0.
- R4: Bit 7 of both registers ignores writes and reads as 0. A write to any other address changes neither register, and a read of any other address returns 0x00.
- R5: For an input pin, `in_value[i]` equals `pin_in[i]` when its polarity/type bit is 1 (active high) and equals the inverse of `pin_in[i]` when the bit is 0 (active low).
- R6: An input pin has `pad_oe[i]` = 0 and `pad_out[i]` = 0, whatever its polarity/type bit holds.
- R7: An output pin whose polarity/type bit is 0 (CMOS) has `pad_oe[i]` = 1 and `pad_out[i]` = `out_data[i]`.
- R8: An output pin whose polarity/type bit is 1 (open-drain) has `pad_out[i]` = 0 and `pad_oe[i]` = NOT `out_data[i]`.
- R9: An output pin reports `in_value[i]` = 0.
- R10: All pin outputs are registered. The outputs after clock edge n follow the register contents held before edge n and the `out_data`/`pin_in` values sampled at edge n. `bus_rdata` after edge n holds the value read at edge n when `bus_rd` is high at that edge (a read in the same cycle as a write returns the old value), and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| out_data | input | 7 | Value to drive on each output pin |
| pin_in | input | 7 | Raw level seen at each pad |
| pad_out | output | 7 | Pad data value |
| pad_oe | output | 7 | Pad driver enable |
| in_value | output | 7 | Polarity-corrected input, 1 = asserted |

## Verification
A corrupted direction or polarity/type bit shows on the pad pins in the cycle after the corruption. The driver enable of that pin turns on or off wrongly, or its input reading flips. The bench also checks `bus_rdata` for the affected register on the next read. Because the reference model is compared on every clock, such a fault is reported one cycle after it appears. The bench varies `out_data` and `pin_in` in each mode, so a CMOS pin mistaken for open-drain, or an active-high pin mistaken for active-low, cannot hide behind a favourable data value.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    PIN_LISTEN = 2'd0,
    PIN_PUSH   = 2'd1,
    PIN_DRAIN  = 2'd2
  } pin_mode_e;

  function automatic pin_mode_e decode_mode(input logic drive, input logic kind);
    if (!drive)    return PIN_LISTEN;
    else if (kind) return PIN_DRAIN;
    else           return PIN_PUSH;
  endfunction
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs #(
  parameter int NUM_PINS = 7,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 8'h2C,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h2D
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic                rd,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] cfg_q
);
  localparam int PAD_W = DATA_W - NUM_PINS;

  logic hit_dir, hit_cfg;
  logic [NUM_PINS-1:0] sel_val;

  assign hit_dir = (addr == DIR_ADDR);
  assign hit_cfg = (addr == CFG_ADDR);

  always_comb begin
    if (hit_dir)      sel_val = dir_q;
    else if (hit_cfg) sel_val = cfg_q;
    else              sel_val = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      cfg_q <= '1;
    end else if (wr) begin
      if (hit_dir) dir_q <= wdata[NUM_PINS-1:0];
      if (hit_cfg) cfg_q <= wdata[NUM_PINS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= {{PAD_W{1'b0}}, sel_val};
    else         rdata <= '0;
  end

  // R2: a direction write lands in the register
  assert_dir_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == DIR_ADDR) |=> (dir_q == $past(wdata[NUM_PINS-1:0])));

  // R3: a polarity/type write lands in the register
  assert_cfg_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == CFG_ADDR) |=> (cfg_q == $past(wdata[NUM_PINS-1:0])));

  // R4: writes elsewhere leave both registers alone
  assert_unmapped_write_R4: assert property (@(posedge clk) disable iff (rst)
    (wr && addr != DIR_ADDR && addr != CFG_ADDR) |=> ($stable(dir_q) && $stable(cfg_q)));

  // R10: no read strobe gives zero read data
  assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (rst)
    !rd |=> (rdata == '0));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] dir_q,
  input  logic [NUM_PINS-1:0] cfg_q,
  input  logic [NUM_PINS-1:0] data,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pin_mode_e mode;
    assign mode = decode_mode(dir_q[i], cfg_q[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[i] <= 1'b0;
        pad_oe[i]  <= 1'b0;
      end else begin
        unique case (mode)
          PIN_PUSH: begin
            pad_out[i] <= data[i];
            pad_oe[i]  <= 1'b1;
          end
          PIN_DRAIN: begin
            pad_out[i] <= 1'b0;
            pad_oe[i]  <= ~data[i];
          end
          default: begin
            pad_out[i] <= 1'b0;
            pad_oe[i]  <= 1'b0;
          end
        endcase
      end
    end
  end

  // R6: a listening pin never enables its driver
  assert_listen_no_drive_R6: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe & ~$past(dir_q)) == '0));

  // R7: a push-pull output always enables its driver
  assert_push_enabled_R7: assert property (@(posedge clk) disable iff (rst)
    (((~pad_oe) & $past(dir_q & ~cfg_q)) == '0));

  // R8: an open-drain output never drives a high level
  assert_drain_never_high_R8: assert property (@(posedge clk) disable iff (rst)
    ((pad_out & $past(dir_q & cfg_q)) == '0));
endmodule

// File: rtl/gpio_in_norm.sv
module gpio_in_norm #(
  parameter int NUM_PINS = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] dir_q,
  input  logic [NUM_PINS-1:0] cfg_q,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] in_value
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst)           in_value[i] <= 1'b0;
      else if (dir_q[i]) in_value[i] <= 1'b0;
      else               in_value[i] <= cfg_q[i] ? pin_in[i] : ~pin_in[i];
    end
  end

  // R9: output pins report no input
  assert_output_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    ((in_value & $past(dir_q)) == '0));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int NUM_PINS = 7,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 8'h2C,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h2D
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] out_data,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] in_value
);
  logic [NUM_PINS-1:0] dir_q, cfg_q;

  gpio_cfg_regs #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .DIR_ADDR(DIR_ADDR), .CFG_ADDR(CFG_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .dir_q(dir_q), .cfg_q(cfg_q)
  );

  gpio_pad_drive #(.NUM_PINS(NUM_PINS)) u_drive (
    .clk(clk), .rst(rst), .dir_q(dir_q), .cfg_q(cfg_q),
    .data(out_data), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  gpio_in_norm #(.NUM_PINS(NUM_PINS)) u_norm (
    .clk(clk), .rst(rst), .dir_q(dir_q), .cfg_q(cfg_q),
    .pin_in(pin_in), .in_value(in_value)
  );

  // R4: the spare read bits stay at zero
  assert_spare_bits_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata[DATA_W-1:NUM_PINS] == '0));
endmodule

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;
  localparam int N = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [N-1:0] out_data = '0, pin_in = '0;
  logic [N-1:0] pad_out, pad_oe, in_value;

  gpio_port_ctrl uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .out_data(out_data), .pin_in(pin_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .in_value(in_value)
  );

  int checks = 0, errors = 0;
  bit armed = 0, done = 0;

  // reference model state
  logic [N-1:0] m_dir, m_cfg, e_oe, e_out, e_in;
  logic [7:0]   e_rd;
  string lab_pad[N], lab_in[N], lab_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_dir = '0; m_cfg = '1;
      e_oe = '0; e_out = '0; e_in = '0; e_rd = '0;
      for (int i = 0; i < N; i++) begin lab_pad[i] = "R1"; lab_in[i] = "R1"; end
      lab_rd = "R1";
    end else begin
      for (int i = 0; i < N; i++) begin
        if (!m_dir[i]) begin
          e_oe[i] = 1'b0; e_out[i] = 1'b0;
          e_in[i] = m_cfg[i] ? pin_in[i] : !pin_in[i];
          lab_pad[i] = "R6"; lab_in[i] = "R5";
        end else if (!m_cfg[i]) begin
          e_oe[i] = 1'b1; e_out[i] = out_data[i]; e_in[i] = 1'b0;
          lab_pad[i] = "R7"; lab_in[i] = "R9";
        end else begin
          e_oe[i] = !out_data[i]; e_out[i] = 1'b0; e_in[i] = 1'b0;
          lab_pad[i] = "R8"; lab_in[i] = "R9";
        end
      end
      if (bus_rd) begin
        if (bus_addr == 8'h2C)      begin e_rd = {1'b0, m_dir}; lab_rd = "R2"; end
        else if (bus_addr == 8'h2D) begin e_rd = {1'b0, m_cfg}; lab_rd = "R3"; end
        else                        begin e_rd = 8'h00;         lab_rd = "R4"; end
      end else begin
        e_rd = 8'h00; lab_rd = "R10";
      end
      if (bus_wr && bus_addr == 8'h2C) m_dir = bus_wdata[N-1:0];
      if (bus_wr && bus_addr == 8'h2D) m_cfg = bus_wdata[N-1:0];
    end
    armed = 1;
  end

  task automatic chk(input string lab, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", lab, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done) begin
      for (int i = 0; i < N; i++) begin
        chk(lab_pad[i], $sformatf("pad_oe[%0d]", i), int'(pad_oe[i]), int'(e_oe[i]));
        chk(lab_pad[i], $sformatf("pad_out[%0d]", i), int'(pad_out[i]), int'(e_out[i]));
        chk(lab_in[i], $sformatf("in_value[%0d]", i), int'(in_value[i]), int'(e_in[i]));
      end
      chk(lab_rd, "bus_rdata", int'(bus_rdata), int'(e_rd));
    end
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bus_wr = 0; bus_rd = 0;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    bus_rd = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic drive(input logic [N-1:0] d, input logic [N-1:0] p);
    @(negedge clk);
    out_data = d; pin_in = p;
    idle(2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    rst = 0;
    rd(8'h2C);  // R2 reset value
    rd(8'h2D);  // R3 reset value
    // R5: all inputs active high
    drive(7'h7F, 7'h55);
    drive(7'h00, 7'h2A);
    // R5: upper three inputs active low
    wr(8'h2D, 8'h0F);
    drive(7'h12, 7'h7F);
    drive(7'h6D, 7'h00);
    // R4: bit 7 ignored
    wr(8'h2D, 8'hFF);
    rd(8'h2D);
    // R8: upper pins open-drain outputs
    wr(8'h2C, 8'hF0);
    rd(8'h2C);
    drive(7'h70, 7'h7F);
    drive(7'h0F, 7'h33);
    // R7: upper pins CMOS
    wr(8'h2D, 8'h0F);
    drive(7'h50, 7'h00);
    drive(7'h2F, 7'h7F);
    // R4: unmapped address
    wr(8'h2E, 8'hAA);
    rd(8'h2E);
    rd(8'h2C);
    // R10: read and write in the same cycle
    @(negedge clk);
    bus_wr = 1; bus_rd = 1; bus_addr = 8'h2C; bus_wdata = 8'h3C;
    idle(1);
    rd(8'h2C);
    // mixed random traffic
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      bus_wr = $urandom_range(0, 3) == 0;
      bus_rd = $urandom_range(0, 2) == 0;
      bus_addr = 8'h2B + 8'($urandom_range(0, 3));
      bus_wdata = 8'($urandom);
      out_data = N'($urandom);
      pin_in = N'($urandom);
    end
    idle(1);
    // R1: reset again mid-run
    @(negedge clk);
    rst = 1;
    idle(3);
    rst = 0;
    rd(8'h2D);
    idle(2);
    finish_run();
  end
endmodule